// File: doc/BRIEF.md
# Triple-Redundant Full Adder with Fault Localisation

This block adds two operand bits and a carry-in using three identical adder copies that run side by side on the same inputs. Two voters, one for the sum and one for the carry, take the bitwise majority of the three copies. The majority gives the corrected result. Each voter also returns a two-bit syndrome that names the copy whose output disagreed. Because the sum and the carry are voted separately, the block can tell a copy that failed completely from a copy whose sum path alone, or carry path alone, went wrong.

Each copy has fault-injection controls on its sum output and on its carry output. These let a bench or a test mode force a copy's output to zero, force it to one, or invert it, before that output reaches the voter. The syndromes are decoded into one-hot flags for each copy. A registered sticky log collects those flags over every cycle in which the input is marked valid, and keeps them until a synchronous clear.

Each copy also drives two auxiliary signals. They are the XOR of the two operands and the inverted XOR of the first operand and the carry-in. The voters never use them.

Top module: `tmr_fa_guard`

## Requirements
- R1: While at most one copy's sum is corrupted, sum_o equals a ^ b ^ cin. Each copy's internal fourth sum input is tied to zero.
- R2: While at most one copy's carry is corrupted, carry_o equals the majority of a, b and cin.
- R3: report[3:2] holds the sum syndrome {SF1,SF2}, where SF1 = x2^x3 and SF2 = x1^x3 over the copies' sums x1..x3. The codes are 00 for no disagreement, 01 for copy 1, 10 for copy 2 and 11 for copy 3.
- R4: report[1:0] holds the carry syndrome {CF1,CF2}. It is formed from the copies' carries with the same rule and the same codes as R3.
- R5: sum_fault[k-1] is high exactly when the sum syndrome names copy k, and carry_fault[k-1] is high exactly when the carry syndrome names copy k. module_fault[k-1] is high when both syndromes name copy k.
- R6: For copy k, the injection mode is taken from bits [2k-1:2k-2] of sum_inj for the sum and of carry_inj for the carry. The codes are 00 pass, 01 force 0, 10 force 1 and 11 invert. A mode counts as a fault only when it changes the copy's value.
- R7: For every copy k, aux_r[k-1] = a ^ b and aux_s[k-1] = ~(a ^ cin). Injection has no effect on either.
- R8: On each rising clock edge with in_valid high and log_clr low, the flags are ORed into fault_log. The layout is fault_log[2:0] for sum_fault, [5:3] for carry_fault and [8:6] for module_fault.
- R9: fault_log becomes zero on a rising edge with log_clr high, even if in_valid is high, and also while rst_n is low at an edge.
- R10: fault_log holds its value on an edge where in_valid and log_clr are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the fault log |
| rst_n | input | 1 | Active-low synchronous reset of the log |
| a | input | 1 | Operand bit A |
| b | input | 1 | Operand bit B |
| cin | input | 1 | Carry-in |
| sum_inj | input | 6 | Per-copy sum injection modes, 2 bits per copy |
| carry_inj | input | 6 | Per-copy carry injection modes, 2 bits per copy |
| in_valid | input | 1 | Marks the current inputs as a logged operation |
| log_clr | input | 1 | Synchronous clear of the fault log |
| sum_o | output | 1 | Voted sum |
| carry_o | output | 1 | Voted carry |
| aux_r | output | 3 | Per-copy a ^ b |
| aux_s | output | 3 | Per-copy ~(a ^ cin) |
| report | output | 4 | {SF1,SF2,CF1,CF2} |
| sum_fault | output | 3 | One-hot sum-disagreement flag per copy |
| carry_fault | output | 3 | One-hot carry-disagreement flag per copy |
| module_fault | output | 3 | Copy flagged in both sum and carry |
| fault_log | output | 9 | Sticky {module, carry, sum} flags |

## Verification
The bench uses the block's fixed three-copy build. That build is small enough to sweep all 8 operand patterns against every injection mode on every copy, for the sum and for the carry. It also sweeps every pairing of a sum fault in one copy with a carry fault in another copy or the same copy, which exercises both the cross-copy reports and the whole-copy reports. Cases with two corrupted copies on the same output fall outside the correction guarantee, so the bench applies them without checking the result. The sticky log is driven through accumulate, hold and clear sequences, and a clear that arrives together with a valid input is included.

// File: rtl/tmr_fa_pkg.sv
package tmr_fa_pkg;
    localparam int NCOPY  = 3;
    localparam int MODE_W = 2;
    localparam int SYN_W  = 2;
    localparam int INJ_W  = NCOPY * MODE_W;
    localparam int LOG_W  = 3 * NCOPY;

    typedef enum logic [MODE_W-1:0] {
        INJ_PASS = 2'b00,
        INJ_LOW  = 2'b01,
        INJ_HIGH = 2'b10,
        INJ_FLIP = 2'b11
    } inj_mode_e;

    typedef struct packed {
        logic [NCOPY-1:0] mod_f;
        logic [NCOPY-1:0] car_f;
        logic [NCOPY-1:0] sum_f;
    } flag_log_t;

    function automatic logic apply_inj(input logic v, input inj_mode_e m);
        logic r;
        case (m)
            INJ_LOW:  r = 1'b0;
            INJ_HIGH: r = 1'b1;
            INJ_FLIP: r = ~v;
            default:  r = v;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/tmr_fa_copy.sv
module tmr_fa_copy
    import tmr_fa_pkg::*;
(
    input  logic              op_a,
    input  logic              op_b,
    input  logic              op_c,
    input  logic              op_d,
    input  logic [MODE_W-1:0] sum_mode,
    input  logic [MODE_W-1:0] car_mode,
    output logic              sum_y,
    output logic              car_y,
    output logic              aux_x,
    output logic              aux_xn
);
    logic sum_raw;
    logic car_raw;

    always_comb begin
        sum_raw = op_a ^ op_b ^ op_c ^ op_d;
        car_raw = (op_a & op_b) | (op_b & op_c) | (op_a & op_c);
        sum_y   = apply_inj(sum_raw, inj_mode_e'(sum_mode));
        car_y   = apply_inj(car_raw, inj_mode_e'(car_mode));
        aux_x   = op_a ^ op_b;
        aux_xn  = ~(op_a ^ op_c);
    end
endmodule

// File: rtl/tmr_fa_voter.sv
module tmr_fa_voter
    import tmr_fa_pkg::*;
(
    input  logic [NCOPY-1:0] vote_in,
    output logic             vote_q,
    output logic [SYN_W-1:0] syn,
    output logic [NCOPY-1:0] culprit
);
    always_comb begin
        vote_q = (vote_in[0] & vote_in[1]) |
                 (vote_in[1] & vote_in[2]) |
                 (vote_in[0] & vote_in[2]);
        syn[1] = vote_in[1] ^ vote_in[2];
        syn[0] = vote_in[0] ^ vote_in[2];
        culprit = '0;
        case (syn)
            2'b01:   culprit[0] = 1'b1;
            2'b10:   culprit[1] = 1'b1;
            2'b11:   culprit[2] = 1'b1;
            default: culprit = '0;
        endcase
    end
endmodule

// File: rtl/tmr_fa_log.sv
module tmr_fa_log
    import tmr_fa_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             log_clr,
    input  flag_log_t        flags,
    output logic [LOG_W-1:0] log_out
);
    flag_log_t log_d, log_q;

    always_comb begin
        log_d = log_q;
        if (log_clr) begin
            log_d = '0;
        end else if (in_valid) begin
            log_d.sum_f = log_q.sum_f | flags.sum_f;
            log_d.car_f = log_q.car_f | flags.car_f;
            log_d.mod_f = log_q.mod_f | flags.mod_f;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) log_q <= '0;
        else        log_q <= log_d;
    end

    assign log_out = log_q;
endmodule

// File: rtl/tmr_fa_guard.sv
module tmr_fa_guard
    import tmr_fa_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a,
    input  logic             b,
    input  logic             cin,
    input  logic [INJ_W-1:0] sum_inj,
    input  logic [INJ_W-1:0] carry_inj,
    input  logic             in_valid,
    input  logic             log_clr,
    output logic             sum_o,
    output logic             carry_o,
    output logic [NCOPY-1:0] aux_r,
    output logic [NCOPY-1:0] aux_s,
    output logic [3:0]       report,
    output logic [NCOPY-1:0] sum_fault,
    output logic [NCOPY-1:0] carry_fault,
    output logic [NCOPY-1:0] module_fault,
    output logic [LOG_W-1:0] fault_log
);
    logic [NCOPY-1:0] copy_sum;
    logic [NCOPY-1:0] copy_car;
    logic [SYN_W-1:0] sum_syn;
    logic [SYN_W-1:0] car_syn;
    flag_log_t        flags_now;

    for (genvar k = 0; k < NCOPY; k++) begin : g_copy
        tmr_fa_copy u_copy (
            .op_a     (a),
            .op_b     (b),
            .op_c     (cin),
            .op_d     (1'b0),
            .sum_mode (sum_inj[k*MODE_W +: MODE_W]),
            .car_mode (carry_inj[k*MODE_W +: MODE_W]),
            .sum_y    (copy_sum[k]),
            .car_y    (copy_car[k]),
            .aux_x    (aux_r[k]),
            .aux_xn   (aux_s[k])
        );
    end

    tmr_fa_voter u_sum_vote (
        .vote_in (copy_sum),
        .vote_q  (sum_o),
        .syn     (sum_syn),
        .culprit (sum_fault)
    );

    tmr_fa_voter u_car_vote (
        .vote_in (copy_car),
        .vote_q  (carry_o),
        .syn     (car_syn),
        .culprit (carry_fault)
    );

    always_comb begin
        report          = {sum_syn, car_syn};
        module_fault    = sum_fault & carry_fault;
        flags_now.sum_f = sum_fault;
        flags_now.car_f = carry_fault;
        flags_now.mod_f = module_fault;
    end

    tmr_fa_log u_log (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .log_clr  (log_clr),
        .flags    (flags_now),
        .log_out  (fault_log)
    );
endmodule

// File: rtl/tmr_fa_guard_chk.sv
module tmr_fa_guard_chk
    import tmr_fa_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             a,
    input logic             b,
    input logic             cin,
    input logic [INJ_W-1:0] sum_inj,
    input logic [INJ_W-1:0] carry_inj,
    input logic             in_valid,
    input logic             log_clr,
    input logic             sum_o,
    input logic             carry_o,
    input logic [NCOPY-1:0] aux_r,
    input logic [NCOPY-1:0] aux_s,
    input logic [3:0]       report,
    input logic [NCOPY-1:0] sum_fault,
    input logic [NCOPY-1:0] carry_fault,
    input logic [NCOPY-1:0] module_fault,
    input logic [LOG_W-1:0] fault_log
);
    logic [NCOPY-1:0] sum_bad;
    logic [NCOPY-1:0] car_bad;

    always_comb begin
        for (int k = 0; k < NCOPY; k++) begin
            sum_bad[k] = sum_inj[k*MODE_W +: MODE_W] != 2'b00;
            car_bad[k] = carry_inj[k*MODE_W +: MODE_W] != 2'b00;
        end
    end

    p_sum_correct_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(sum_bad) <= 1) |-> (sum_o == (a ^ b ^ cin)));

    p_carry_correct_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(car_bad) <= 1) |-> (carry_o == ((a & b) | (b & cin) | (a & cin))));

    p_sum_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_bad == '0) |-> (report[3:2] == 2'b00));

    p_carry_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (car_bad == '0) |-> (report[1:0] == 2'b00));

    p_flag_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sum_fault) && $onehot0(carry_fault) &&
        ((sum_fault != '0) == (report[3:2] != 2'b00)) &&
        ((module_fault & ~carry_fault) == '0));

    p_aux_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_r == {NCOPY{a ^ b}}) && (aux_s == {NCOPY{~(a ^ cin)}}));

    p_log_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && !$past(log_clr)) |->
        ((fault_log & $past(fault_log)) == $past(fault_log)));

    p_log_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(log_clr)) |-> (fault_log == '0));

    p_log_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid) && !$past(log_clr)) |-> $stable(fault_log));
endmodule

bind tmr_fa_guard tmr_fa_guard_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .a            (a),
    .b            (b),
    .cin          (cin),
    .sum_inj      (sum_inj),
    .carry_inj    (carry_inj),
    .in_valid     (in_valid),
    .log_clr      (log_clr),
    .sum_o        (sum_o),
    .carry_o      (carry_o),
    .aux_r        (aux_r),
    .aux_s        (aux_s),
    .report       (report),
    .sum_fault    (sum_fault),
    .carry_fault  (carry_fault),
    .module_fault (module_fault),
    .fault_log    (fault_log)
);

// File: tb/tmr_fa_guard_bench.sv
module tmr_fa_guard_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       a, b, cin;
    logic [5:0] sum_inj, carry_inj;
    logic       in_valid, log_clr;
    logic       sum_o, carry_o;
    logic [2:0] aux_r, aux_s;
    logic [3:0] report;
    logic [2:0] sum_fault, carry_fault, module_fault;
    logic [8:0] fault_log;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_fa_guard u_tmr_fa_guard (
        .clk (clk), .rst_n (rst_n), .a (a), .b (b), .cin (cin),
        .sum_inj (sum_inj), .carry_inj (carry_inj),
        .in_valid (in_valid), .log_clr (log_clr),
        .sum_o (sum_o), .carry_o (carry_o), .aux_r (aux_r), .aux_s (aux_s),
        .report (report), .sum_fault (sum_fault), .carry_fault (carry_fault),
        .module_fault (module_fault), .fault_log (fault_log)
    );

    function automatic logic inj_val(input logic v, input logic [1:0] m);
        case (m)
            2'b01:   return 1'b0;
            2'b10:   return 1'b1;
            2'b11:   return ~v;
            default: return v;
        endcase
    endfunction

    function automatic logic [1:0] code_of(input logic [2:0] bad);
        case (bad)
            3'b001:  return 2'b01;
            3'b010:  return 2'b10;
            3'b100:  return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply_and_check(input logic [2:0] ops, input logic [5:0] sm, input logic [5:0] cm);
        logic ref_s, ref_c;
        logic [2:0] sbad, cbad;
        @(negedge clk);
        {a, b, cin} = ops;
        sum_inj = sm;
        carry_inj = cm;
        #1;
        ref_s = ops[2] ^ ops[1] ^ ops[0];
        ref_c = (ops[2] & ops[1]) | (ops[1] & ops[0]) | (ops[2] & ops[0]);
        for (int k = 0; k < 3; k++) begin
            sbad[k] = inj_val(ref_s, sm[2*k +: 2]) != ref_s;
            cbad[k] = inj_val(ref_c, cm[2*k +: 2]) != ref_c;
        end
        check("R1 sum", sum_o, ref_s);
        check("R2 carry", carry_o, ref_c);
        check("R3 sum syndrome", report[3:2], code_of(sbad));
        check("R4 carry syndrome", report[1:0], code_of(cbad));
        check("R5 sum flags", sum_fault, sbad);
        check("R5 carry flags", carry_fault, cbad);
        check("R5 module flags", module_fault, sbad & cbad);
        check("R7 aux", {aux_r, aux_s}, {{3{ops[2] ^ ops[1]}}, {3{~(ops[2] ^ ops[0])}}});
    endtask

    task automatic log_step(input logic [5:0] sm, input logic [5:0] cm,
                            input logic v, input logic clr, input logic [8:0] exp, input string req);
        @(negedge clk);
        {a, b, cin} = 3'b011;
        sum_inj = sm;
        carry_inj = cm;
        in_valid = v;
        log_clr = clr;
        @(posedge clk);
        @(negedge clk);
        check(req, fault_log, exp);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; a = 0; b = 0; cin = 0;
        sum_inj = '0; carry_inj = '0; in_valid = 0; log_clr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 reset log", fault_log, 9'h000);
        rst_n = 1'b1;

        // R1 R2 R3 R4 R6: every single-copy mode on sum and on carry
        for (int op = 0; op < 8; op++)
            for (int k = 0; k < 3; k++)
                for (int m = 0; m < 4; m++) begin
                    apply_and_check(3'(op), 6'(m << (2*k)), 6'b0);
                    apply_and_check(3'(op), 6'b0, 6'(m << (2*k)));
                end

        // R5: sum fault in copy i with carry fault in copy j
        for (int op = 0; op < 8; op++)
            for (int i = 0; i < 3; i++)
                for (int j = 0; j < 3; j++)
                    apply_and_check(3'(op), 6'(3 << (2*i)), 6'(3 << (2*j)));

        // two corrupted copies on one output: outside the guarantee, applied only
        for (int op = 0; op < 8; op++) begin
            @(negedge clk);
            {a, b, cin} = 3'(op);
            sum_inj = 6'b00_11_11;
            carry_inj = 6'b11_00_11;
        end

        // R8 R9 R10: sticky log (operands 011 give sum 0, carry 1)
        log_step(6'b0, 6'b0, 1'b0, 1'b1, 9'h000, "R9 clear");
        log_step(6'b00_11_00, 6'b0, 1'b1, 1'b0, 9'b000_000_010, "R8 sum copy2");
        log_step(6'b0, 6'b01_00_00, 1'b1, 1'b0, 9'b000_100_010, "R8 carry copy3");
        log_step(6'b00_00_10, 6'b00_00_01, 1'b0, 1'b0, 9'b000_100_010, "R10 hold");
        log_step(6'b00_00_10, 6'b00_00_01, 1'b1, 1'b0, 9'b001_101_011, "R8 module copy1");
        log_step(6'b0, 6'b0, 1'b1, 1'b0, 9'b001_101_011, "R8 no new fault");
        log_step(6'b11_00_00, 6'b0, 1'b1, 1'b1, 9'h000, "R9 clear beats valid");
        log_step(6'b11_00_00, 6'b0, 1'b1, 1'b0, 9'b000_000_100, "R8 after clear");
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R9 reset clears log", fault_log, 9'h000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule